// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt sources that belong to each core of a four-core cluster and turns them into one pending word and one level interrupt line per core. Every core has four generic-timer lines and four mailbox summary lines of its own. One performance-monitor line is shared, and software routes it to any subset of cores. One fast interrupt from an external graphics domain always goes to core 0.

Software programs the block over a simple word-wide register bus. Timer and mailbox enables are plain per-core words, which software updates by read-modify-write. Performance-monitor routing uses a pair of write-one-to-set and write-one-to-clear addresses, so no read is needed to change one core's route. The pending word shows raw source state. Software services the lowest set bit first. The block has no vectoring and no priority logic.

The block has no control sequence. The registers and the per-core pending stage make up all of its state.

Top module: `lirq_router`

## Requirements
- R1: After reset every timer enable, mailbox enable and routing bit is zero. With the shared fast line low, every `core_irq` bit and every pending word is zero even while all other sources are active.
- R2: The timer enable word of core c sits at byte address 0x00 + 4*c. Its bit n gates timer line `tmr_irq[4*c+n]` onto pending bit n of core c. Bits 31:4 are not stored and read as zero.
- R3: The mailbox enable word of core c sits at byte address 0x10 + 4*c. Its bit m gates `mbx_irq[4*c+m]` onto pending bit 4+m of core c. Bit 0 controls mailbox 0. Bits 31:4 read as zero.
- R4: A write to 0x20 sets every routing bit whose write-data bit (3:0) is one. Zero bits leave their routing bits unchanged.
- R5: A write to 0x24 clears every routing bit whose write-data bit is one. Zero bits leave their routing bits unchanged. A read of either 0x20 or 0x24 returns the routing mask in bits 3:0.
- R6: The shared fast line `gpu_fast` appears ungated at pending bit 8 of core 0. It never appears in the pending word of cores 1 to 3.
- R7: The performance-monitor line `pmu_irq` appears at pending bit 9 of every core whose routing bit is one.
- R8: The pending word of core c reads at 0x30 + 4*c. It follows source levels one clock after they change, drops again when the source drops, and bits 31:10 read as zero.
- R9: `core_irq[c]` is high exactly when the pending word of core c is non-zero, and it changes in the same cycle as that word.
- R10: Read data appears on `bus_rdata` one cycle after the read request. A read of an unused or unaligned address returns zero. Writes to pending or unused addresses change nothing.
- R11: A write to one core's enable word leaves the pending state of every other core untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tmr_irq | input | 16 | Timer lines, four per core, core c at bits 4c+3:4c |
| mbx_irq | input | 16 | Mailbox summary lines, four per core |
| gpu_fast | input | 1 | Shared fast interrupt from the graphics domain |
| pmu_irq | input | 1 | Performance-monitor interrupt line |
| core_irq | output | 4 | Level interrupt per core |

## Verification
A source change reaches the pending register at the next rising edge, so `core_irq` moves one edge after a source changes. A pending read that is issued after that edge returns the new value one further edge later. An enable or routing write takes effect at its own edge, and the pending word follows at the edge after that. For this reason every pending read in the bench waits one idle cycle before it issues the request. Interrupt-line checks are sampled just after the edge that is due to move the line. Checks made just before that edge confirm that the line has not yet moved.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int LIRQ_NCORE = 4;
    localparam int LIRQ_NTMR  = 4;
    localparam int LIRQ_NMBX  = 4;
    localparam int LIRQ_AW    = 6;
    localparam int LIRQ_DW    = 32;

    // byte addresses of the register banks
    localparam int TMR_BASE  = 'h00;
    localparam int MBX_BASE  = 'h10;
    localparam int ROUTE_SET = 'h20;
    localparam int ROUTE_CLR = 'h24;
    localparam int PEND_BASE = 'h30;

    function automatic bit lirq_in_bank(input int a, input int base, input int ncore);
        return (a >= base) && (a < base + 4 * ncore) && ((a % 4) == 0);
    endfunction

    function automatic bit lirq_is_mapped(input int a, input int ncore);
        return lirq_in_bank(a, TMR_BASE, ncore) || lirq_in_bank(a, MBX_BASE, ncore) ||
               lirq_in_bank(a, PEND_BASE, ncore) || (a == ROUTE_SET) || (a == ROUTE_CLR);
    endfunction
endpackage

// File: rtl/lirq_regfile.sv
module lirq_regfile
    import lirq_pkg::*;
#(
    parameter int NCORE = LIRQ_NCORE,
    parameter int NTMR  = LIRQ_NTMR,
    parameter int NMBX  = LIRQ_NMBX,
    parameter int AW    = LIRQ_AW,
    parameter int DW    = LIRQ_DW,
    parameter int PW    = NTMR + NMBX + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    input  logic [NCORE*PW-1:0]   pend_flat,
    output logic [NCORE*NTMR-1:0] tmr_en,
    output logic [NCORE*NMBX-1:0] mbx_en,
    output logic [NCORE-1:0]      route,
    output logic [DW-1:0]         bus_rdata
);
    localparam int USEW = (NTMR > NMBX) ? ((NTMR > NCORE) ? NTMR : NCORE)
                                        : ((NMBX > NCORE) ? NMBX : NCORE);

    logic [NTMR-1:0]  tmr_en_q [NCORE];
    logic [NMBX-1:0]  mbx_en_q [NCORE];
    logic [NCORE-1:0] route_q;
    logic [DW-1:0]    rdata_q;
    logic [DW-1:0]    rd_next;
    logic             wr_hit;
    logic             rd_hit;
    logic             unused_wdata;

    assign wr_hit       = bus_req && bus_we;
    assign rd_hit       = bus_req && !bus_we;
    assign unused_wdata = ^bus_wdata[DW-1:USEW];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCORE; c++) begin
                tmr_en_q[c] <= '0;
                mbx_en_q[c] <= '0;
            end
            route_q <= '0;
        end else if (wr_hit) begin
            for (int c = 0; c < NCORE; c++) begin
                if (bus_addr == AW'(TMR_BASE + 4 * c)) tmr_en_q[c] <= bus_wdata[NTMR-1:0];
                if (bus_addr == AW'(MBX_BASE + 4 * c)) mbx_en_q[c] <= bus_wdata[NMBX-1:0];
            end
            if (bus_addr == AW'(ROUTE_SET)) route_q <= route_q | bus_wdata[NCORE-1:0];
            if (bus_addr == AW'(ROUTE_CLR)) route_q <= route_q & ~bus_wdata[NCORE-1:0];
        end
    end

    always_comb begin
        rd_next = '0;
        for (int c = 0; c < NCORE; c++) begin
            if (bus_addr == AW'(TMR_BASE + 4 * c))  rd_next[NTMR-1:0] = tmr_en_q[c];
            if (bus_addr == AW'(MBX_BASE + 4 * c))  rd_next[NMBX-1:0] = mbx_en_q[c];
            if (bus_addr == AW'(PEND_BASE + 4 * c)) rd_next[PW-1:0]   = pend_flat[c*PW +: PW];
        end
        if (bus_addr == AW'(ROUTE_SET) || bus_addr == AW'(ROUTE_CLR))
            rd_next[NCORE-1:0] = route_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_hit) rdata_q <= rd_next;
    end

    genvar g;
    generate
        for (g = 0; g < NCORE; g++) begin : g_flat
            assign tmr_en[g*NTMR +: NTMR] = tmr_en_q[g];
            assign mbx_en[g*NMBX +: NMBX] = mbx_en_q[g];
        end
    endgenerate

    assign route     = route_q;
    assign bus_rdata = rdata_q;
endmodule

// File: rtl/lirq_core_pend.sv
module lirq_core_pend #(
    parameter int NTMR = 4,
    parameter int NMBX = 4,
    parameter int PW   = NTMR + NMBX + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTMR-1:0] tmr_lvl,
    input  logic [NTMR-1:0] tmr_en,
    input  logic [NMBX-1:0] mbx_lvl,
    input  logic [NMBX-1:0] mbx_en,
    input  logic            fast_lvl,
    input  logic            pmu_lvl,
    input  logic            pmu_route,
    output logic [PW-1:0]   pend,
    output logic            irq
);
    localparam int MBX_LSB  = NTMR;
    localparam int FAST_BIT = NTMR + NMBX;
    localparam int PMU_BIT  = FAST_BIT + 1;

    logic [PW-1:0] pend_next;
    logic [PW-1:0] pend_q;

    always_comb begin
        pend_next                    = '0;
        pend_next[NTMR-1:0]          = tmr_lvl & tmr_en;
        pend_next[MBX_LSB +: NMBX]   = mbx_lvl & mbx_en;
        pend_next[FAST_BIT]          = fast_lvl;
        pend_next[PMU_BIT]           = pmu_lvl & pmu_route;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_next;
    end

    assign pend = pend_q;
    assign irq  = |pend_q;
endmodule

// File: rtl/lirq_router.sv
module lirq_router
    import lirq_pkg::*;
#(
    parameter int NCORE = LIRQ_NCORE,
    parameter int NTMR  = LIRQ_NTMR,
    parameter int NMBX  = LIRQ_NMBX,
    parameter int AW    = LIRQ_AW,
    parameter int DW    = LIRQ_DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [NCORE*NTMR-1:0] tmr_irq,
    input  logic [NCORE*NMBX-1:0] mbx_irq,
    input  logic                  gpu_fast,
    input  logic                  pmu_irq,
    output logic [NCORE-1:0]      core_irq
);
    localparam int PW = NTMR + NMBX + 2;

    logic [NCORE*NTMR-1:0] tmr_en;
    logic [NCORE*NMBX-1:0] mbx_en;
    logic [NCORE-1:0]      pmu_route;
    logic [NCORE*PW-1:0]   pend_flat;

    lirq_regfile #(
        .NCORE(NCORE), .NTMR(NTMR), .NMBX(NMBX), .AW(AW), .DW(DW), .PW(PW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pend_flat(pend_flat),
        .tmr_en   (tmr_en),
        .mbx_en   (mbx_en),
        .route    (pmu_route),
        .bus_rdata(bus_rdata)
    );

    genvar c;
    generate
        for (c = 0; c < NCORE; c++) begin : g_core
            logic fast_c;
            if (c == 0) begin : g_fast
                assign fast_c = gpu_fast;
            end else begin : g_nofast
                assign fast_c = 1'b0;
            end

            lirq_core_pend #(.NTMR(NTMR), .NMBX(NMBX), .PW(PW)) u_pend (
                .clk      (clk),
                .rst_n    (rst_n),
                .tmr_lvl  (tmr_irq[c*NTMR +: NTMR]),
                .tmr_en   (tmr_en[c*NTMR +: NTMR]),
                .mbx_lvl  (mbx_irq[c*NMBX +: NMBX]),
                .mbx_en   (mbx_en[c*NMBX +: NMBX]),
                .fast_lvl (fast_c),
                .pmu_lvl  (pmu_irq),
                .pmu_route(pmu_route[c]),
                .pend     (pend_flat[c*PW +: PW]),
                .irq      (core_irq[c])
            );
        end
    endgenerate
endmodule

// File: rtl/lirq_router_chk.sv
module lirq_router_chk
    import lirq_pkg::*;
#(
    parameter int NCORE = LIRQ_NCORE,
    parameter int AW    = LIRQ_AW,
    parameter int DW    = LIRQ_DW,
    parameter int PW    = LIRQ_NTMR + LIRQ_NMBX + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [NCORE-1:0] wr_bits,
    input logic [DW-1:0]    bus_rdata,
    input logic [NCORE-1:0] core_irq,
    input logic             src_any,
    input logic [NCORE-1:0] route
);
    logic rd_unmapped;
    logic rd_pend;

    assign rd_unmapped = bus_req && !bus_we && !lirq_is_mapped(int'(bus_addr), NCORE);
    assign rd_pend     = bus_req && !bus_we && lirq_in_bank(int'(bus_addr), PEND_BASE, NCORE);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (core_irq == '0));

    // R4
    route_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == AW'(ROUTE_SET))
        |=> (route == ($past(route) | $past(wr_bits))));

    // R5
    route_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == AW'(ROUTE_CLR))
        |=> (route == ($past(route) & ~$past(wr_bits))));

    // R8
    pend_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |=> (bus_rdata[DW-1:PW] == '0));

    // R9
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_irq) |-> $past(src_any));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> (bus_rdata == '0));
endmodule

bind lirq_router lirq_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_bits  (bus_wdata[3:0]),
    .bus_rdata(bus_rdata),
    .core_irq (core_irq),
    .src_any  ((|tmr_irq) | (|mbx_irq) | gpu_fast | pmu_irq),
    .route    (pmu_route)
);

// File: tb/lirq_router_tb.sv
module lirq_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tmr_irq = '0;
    logic [15:0] mbx_irq = '0;
    logic        gpu_fast = 1'b0;
    logic        pmu_irq = 1'b0;
    logic [3:0]  core_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lirq_router u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_irq(tmr_irq), .mbx_irq(mbx_irq), .gpu_fast(gpu_fast),
        .pmu_irq(pmu_irq), .core_irq(core_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    // one idle edge lets the pending stage catch up before the read
    task automatic read_pend(input int core, output logic [31:0] d);
        @(posedge clk); #1;
        bus_read(6'(32'h30 + 4 * core), d);
    endtask

    task automatic clear_all();
        for (int c = 0; c < 4; c++) begin
            bus_write(6'(4 * c), 32'h0);
            bus_write(6'(32'h10 + 4 * c), 32'h0);
        end
        bus_write(6'h24, 32'hF);
        tmr_irq = '0; mbx_irq = '0; gpu_fast = 1'b0; pmu_irq = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        tmr_irq = '1; mbx_irq = '1; pmu_irq = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 core_irq after reset", 32'(core_irq), 32'h0);
        for (int c = 0; c < 4; c++) begin
            read_pend(c, d);
            check("R1 pending after reset", d, 32'h0);
        end
        bus_read(6'h20, d);
        check("R1 routing after reset", d, 32'h0);
        clear_all();
    endtask

    task automatic t_timer();
        logic [31:0] d;
        tmr_irq = '1;
        bus_write(6'h04, 32'h0000_0004);
        read_pend(1, d);
        check("R2 core1 timer bit2", d, 32'h4);
        check("R9 core_irq with timer", 32'(core_irq), 32'h2);
        read_pend(0, d);
        check("R11 core0 untouched", d, 32'h0);
        read_pend(3, d);
        check("R11 core3 untouched", d, 32'h0);
        bus_write(6'h08, 32'hFFFF_FFF5);
        bus_read(6'h08, d);
        check("R2 timer word readback", d, 32'h5);
        read_pend(2, d);
        check("R2 core2 timers 0 and 2", d, 32'h5);
        clear_all();
    endtask

    task automatic t_mbox();
        logic [31:0] d;
        mbx_irq = '1;
        bus_write(6'h1C, 32'h1);
        read_pend(3, d);
        check("R3 core3 mailbox0 at bit4", d, 32'h10);
        bus_write(6'h1C, 32'hFFFF_FFFF);
        bus_read(6'h1C, d);
        check("R3 mailbox word readback", d, 32'hF);
        read_pend(3, d);
        check("R3 core3 all mailboxes", d, 32'hF0);
        clear_all();
    endtask

    task automatic t_pmu();
        logic [31:0] d;
        pmu_irq = 1'b1;
        bus_write(6'h20, 32'h5);
        bus_read(6'h20, d);
        check("R4 route after set", d, 32'h5);
        read_pend(0, d);
        check("R7 core0 pmu bit9", d, 32'h200);
        read_pend(1, d);
        check("R7 core1 not routed", d, 32'h0);
        bus_write(6'h20, 32'h0);
        bus_read(6'h24, d);
        check("R4 zero set keeps route", d, 32'h5);
        bus_write(6'h24, 32'h1);
        bus_read(6'h24, d);
        check("R5 route after clear", d, 32'h4);
        read_pend(0, d);
        check("R5 core0 pmu cleared", d, 32'h0);
        read_pend(2, d);
        check("R7 core2 still routed", d, 32'h200);
        clear_all();
    endtask

    task automatic t_fast();
        logic [31:0] d;
        gpu_fast = 1'b1;
        read_pend(0, d);
        check("R6 core0 fast bit8", d, 32'h100);
        read_pend(1, d);
        check("R6 core1 no fast", d, 32'h0);
        check("R6 only core0 irq", 32'(core_irq), 32'h1);
        @(negedge clk);
        gpu_fast = 1'b0;
        #1 check("R9 irq holds until edge", 32'(core_irq), 32'h1);
        @(posedge clk); #1;
        check("R8 level drop reaches irq", 32'(core_irq), 32'h0);
        read_pend(0, d);
        check("R8 pending drops with source", d, 32'h0);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        tmr_irq = '1;
        bus_write(6'h00, 32'h3);
        bus_read(6'h28, d);
        check("R10 unused address reads zero", d, 32'h0);
        bus_read(6'h02, d);
        check("R10 unaligned address reads zero", d, 32'h0);
        bus_write(6'h30, 32'hFFFF_FFFF);
        bus_write(6'h2C, 32'hFFFF_FFFF);
        read_pend(0, d);
        check("R10 write to pending ignored", d, 32'h3);
        bus_read(6'h24, d);
        check("R10 route untouched by stray writes", d, 32'h0);
        read_pend(1, d);
        check("R10 core1 untouched by stray writes", d, 32'h0);
        clear_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_timer();
        t_mbox();
        t_pmu();
        t_fast();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule